// File: doc/BRIEF.md
# Timestamped Sample Cluster Packer

The packer sits between the input sampling front end of a logic analyzer and its sample memory. Once per event slot, nominally every 20 ns, it takes the raw channel sub-samples and folds them into one 16-bit event word. At the slowest setting an event carries one sample of 16 channels. At twice that rate it carries two sub-samples of 8 channels, and at four times that rate it carries four sub-samples of 4 channels. Within the event word the sub-samples of a channel sit side by side.

Seven consecutive events form a cluster. The cluster goes out as eight 16-bit words on a valid-qualified stream. The first word is the free-running 16-bit slot timestamp taken at the cluster's first slot, and the seven events follow. A cluster whose seven events all equal the last event of the previous cluster is not written. The timestamp keeps advancing, so a reader recovers the hold time from the jump between stored timestamps. Memory is addressed in words: 8 words make a cluster and 512 words (64 clusters) make a chunk.

A start strobe begins a capture at word address zero. A stop strobe ends it, and from then on the committed word count is held as the stop position until the next start.

Top module: `tsc_packer`

## Requirements
- R1: After reset, `out_valid` is 0, `stop_pos` is 0 and `running` is 0.
- R2: The slot timestamp starts at 0 after reset and increments on every `slot_tick`, whether or not a capture is running. The first word of each emitted cluster is the timestamp value at the cluster's first slot, and `out_is_ts` is 1 with that word only.
- R3: An emitted cluster occupies 8 consecutive valid cycles: the timestamp word, then events 0 to 6 in slot order.
- R4: With `mode` = 0 (one sub-sample), bit l of the event equals bit l of lane 0 (`lanes[15:0]`).
- R5: With `mode` = 1 (two sub-samples, 8 channels), event bit 2*l+k equals bit l of lane k (`lanes[16*k+l]`), for l < 8 and k < 2.
- R6: With `mode` = 2 (four sub-samples, 4 channels), event bit 4*l+k equals `lanes[16*k+l]`, for l < 4 and k < 4. `mode` = 3 folds like `mode` = 0.
- R7: A cluster is suppressed when all seven of its events equal the last event of the previous cluster, whether that cluster was emitted or not. A suppressed cluster produces no output words and no address advance.
- R8: The first complete cluster after a start is always emitted. This holds even when all its events equal zero, which is the held value a start restores.
- R9: `out_addr` is 0 for the first word after a start and rises by one per emitted word, so every timestamp word lies at a multiple of 8. The cluster index within a chunk is `out_addr[8:3]` and the chunk number is `out_addr[23:9]`.
- R10: While `running` is 0, slot ticks fill no cluster and emit nothing. A stop discards a partly filled cluster. `stop_pos` equals 8 times the number of clusters emitted since the last start and stays unchanged until the next start.
- R11: `run_start` sets `running`, clears `stop_pos` and the cluster fill. A `run_stop` in the same cycle as a cluster's seventh tick discards that cluster.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_start | input | 1 | Capture start strobe |
| run_stop | input | 1 | Capture stop strobe |
| mode | input | 2 | Fold mode: 0 one, 1 two, 2 four sub-samples per event |
| slot_tick | input | 1 | One event slot has elapsed; `lanes` is valid |
| lanes | input | 64 | Four 16-bit sub-sample lanes, lane k at bits 16*k+15..16*k |
| out_valid | output | 1 | Output word is valid |
| out_word | output | 16 | Timestamp or event word |
| out_is_ts | output | 1 | Current word is a cluster timestamp |
| out_addr | output | 24 | Word address of the current word |
| stop_pos | output | 24 | Words committed since the last start |
| running | output | 1 | Capture active |

## Verification
The assertions take for granted that two slot ticks never come in adjacent cycles. With that spacing, the 8-cycle burst of one cluster always ends before the next cluster completes. They also assume that start and stop are never raised together and that a start does not arrive during a burst. The stimulus drives each slot as a one-cycle tick followed by at least one idle cycle. It raises the strobes only between slots and waits for the queue to drain before a start. The bench's reference model stores nothing in sub-sample fold order: it computes expected events from the per-channel rule, on the same tick sequence.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    localparam int TS_W        = 16;
    localparam int EV_W        = 16;
    localparam int LANES       = 4;
    localparam int EV_PER_CL   = 7;
    localparam int WORDS_PER_CL = EV_PER_CL + 1;
    localparam int IDX_W       = $clog2(WORDS_PER_CL);

    typedef enum logic [1:0] {
        FOLD_X1  = 2'd0,
        FOLD_X2  = 2'd1,
        FOLD_X4  = 2'd2,
        FOLD_RSV = 2'd3
    } fold_mode_t;

    typedef struct packed {
        logic [TS_W-1:0]                 ts;
        logic [EV_PER_CL-1:0][EV_W-1:0]  ev;
    } cluster_t;

    function automatic int sub_per_event(fold_mode_t m);
        case (m)
            FOLD_X2: return 2;
            FOLD_X4: return 4;
            default: return 1;
        endcase
    endfunction
endpackage

// File: rtl/tsc_slot_timer.sv
module tsc_slot_timer
    import tsc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    output logic [TS_W-1:0] ts
);
    always_ff @(posedge clk) begin
        if (rst)
            ts <= '0;
        else if (tick)
            ts <= ts + 1'b1;
    end
endmodule

// File: rtl/tsc_event_fold.sv
module tsc_event_fold
    import tsc_pkg::*;
(
    input  fold_mode_t              mode,
    input  logic [LANES*EV_W-1:0]   lanes,
    output logic [EV_W-1:0]         ev
);
    // Each event bit picks its lane (sub-sample) and channel per fold ratio.
    for (genvar b = 0; b < EV_W; b++) begin : g_bit
        localparam int CH2 = b / 2;
        localparam int SB2 = b % 2;
        localparam int CH4 = b / 4;
        localparam int SB4 = b % 4;
        always_comb begin
            case (sub_per_event(mode))
                2:       ev[b] = lanes[SB2*EV_W + CH2];
                4:       ev[b] = lanes[SB4*EV_W + CH4];
                default: ev[b] = lanes[b];
            endcase
        end
    end
endmodule

// File: rtl/tsc_cluster_fill.sv
module tsc_cluster_fill
    import tsc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            accept,
    input  logic [EV_W-1:0] ev,
    input  logic [TS_W-1:0] ts,
    output logic            commit,
    output cluster_t        cl
);
    localparam int LAST = EV_PER_CL - 1;

    logic [IDX_W-1:0]  idx;
    logic [EV_W-1:0]   evbuf [LAST];
    logic [TS_W-1:0]   ts_cap;
    logic [EV_W-1:0]   held;
    logic              chg;
    logic              first;
    logic              last_slot;
    logic              diff_now;

    always_comb begin
        last_slot = accept && (idx == IDX_W'(LAST));
        diff_now  = (ev != held);
        commit    = last_slot && (first || chg || diff_now);
        cl.ts     = ts_cap;
        for (int i = 0; i < LAST; i++)
            cl.ev[i] = evbuf[i];
        cl.ev[LAST] = ev;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx    <= '0;
            ts_cap <= '0;
            held   <= '0;
            chg    <= 1'b0;
            first  <= 1'b0;
            for (int i = 0; i < LAST; i++)
                evbuf[i] <= '0;
        end else if (start) begin
            idx   <= '0;
            held  <= '0;
            chg   <= 1'b0;
            first <= 1'b1;
        end else if (accept) begin
            for (int i = 0; i < LAST; i++)
                if (idx == IDX_W'(i))
                    evbuf[i] <= ev;
            if (idx == '0) begin
                ts_cap <= ts;
                chg    <= diff_now;
            end else begin
                chg    <= chg | diff_now;
            end
            if (last_slot) begin
                idx   <= '0;
                held  <= ev;
                first <= 1'b0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tsc_cluster_emit.sv
module tsc_cluster_emit
    import tsc_pkg::*;
#(
    parameter int POS_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             commit,
    input  cluster_t         cl,
    output logic             out_valid,
    output logic [EV_W-1:0]  out_word,
    output logic             out_is_ts,
    output logic [POS_W-1:0] out_addr,
    output logic [POS_W-1:0] cpos
);
    cluster_t          obuf;
    logic              active;
    logic [IDX_W-1:0]  widx;
    logic [IDX_W-1:0]  eidx;
    logic [POS_W-1:0]  wpos;

    always_comb begin
        eidx      = widx - 1'b1;
        out_valid = active;
        out_is_ts = active && (widx == '0);
        out_word  = (widx == '0) ? obuf.ts : obuf.ev[eidx];
        out_addr  = wpos;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            obuf   <= '0;
            active <= 1'b0;
            widx   <= '0;
            wpos   <= '0;
            cpos   <= '0;
        end else if (start) begin
            active <= 1'b0;
            widx   <= '0;
            wpos   <= '0;
            cpos   <= '0;
        end else begin
            if (active) begin
                wpos <= wpos + 1'b1;
                widx <= widx + 1'b1;
                if (widx == IDX_W'(WORDS_PER_CL - 1))
                    active <= 1'b0;
            end
            if (commit) begin
                obuf   <= cl;
                active <= 1'b1;
                widx   <= '0;
                cpos   <= cpos + POS_W'(WORDS_PER_CL);
            end
        end
    end
endmodule

// File: rtl/tsc_packer.sv
module tsc_packer
    import tsc_pkg::*;
#(
    parameter int POS_W = 24
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   run_start,
    input  logic                   run_stop,
    input  logic [1:0]             mode,
    input  logic                   slot_tick,
    input  logic [LANES*EV_W-1:0]  lanes,
    output logic                   out_valid,
    output logic [EV_W-1:0]        out_word,
    output logic                   out_is_ts,
    output logic [POS_W-1:0]       out_addr,
    output logic [POS_W-1:0]       stop_pos,
    output logic                   running
);
    logic [TS_W-1:0] ts;
    logic [EV_W-1:0] ev;
    logic            accept;
    logic            commit;
    cluster_t        cl;

    always_ff @(posedge clk) begin
        if (rst)
            running <= 1'b0;
        else if (run_start)
            running <= 1'b1;
        else if (run_stop)
            running <= 1'b0;
    end

    assign accept = slot_tick && running && !run_stop && !run_start;

    tsc_slot_timer u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (slot_tick),
        .ts   (ts)
    );

    tsc_event_fold u_fold (
        .mode  (fold_mode_t'(mode)),
        .lanes (lanes),
        .ev    (ev)
    );

    tsc_cluster_fill u_fill (
        .clk    (clk),
        .rst    (rst),
        .start  (run_start),
        .accept (accept),
        .ev     (ev),
        .ts     (ts),
        .commit (commit),
        .cl     (cl)
    );

    tsc_cluster_emit #(.POS_W(POS_W)) u_emit (
        .clk       (clk),
        .rst       (rst),
        .start     (run_start),
        .commit    (commit),
        .cl        (cl),
        .out_valid (out_valid),
        .out_word  (out_word),
        .out_is_ts (out_is_ts),
        .out_addr  (out_addr),
        .cpos      (stop_pos)
    );
endmodule

// File: rtl/tsc_packer_chk.sv
module tsc_packer_chk #(
    parameter int POS_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             run_start,
    input logic             run_stop,
    input logic             slot_tick,
    input logic             out_valid,
    input logic             out_is_ts,
    input logic [POS_W-1:0] out_addr,
    input logic [POS_W-1:0] stop_pos,
    input logic             running
);
    // R1: reset state
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!out_valid && stop_pos == '0 && !running));

    // R2: a burst opens with the timestamp word
    a_r2_ts_leads: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> out_is_ts);

    // R3: the timestamp is followed by an event word
    a_r3_event_follows: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_is_ts) |=> (out_valid && !out_is_ts));

    // R3: input assumption, slot ticks never adjacent
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        slot_tick |=> !slot_tick);

    // R9: consecutive words have consecutive addresses
    a_r9_addr_step: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_is_ts) |-> (out_addr == $past(out_addr) + 1'b1));

    // R9: timestamp words are cluster aligned
    a_r9_ts_aligned: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_is_ts) |-> (out_addr[2:0] == 3'd0));

    // R10: stop position frozen while idle
    a_r10_stop_frozen: assert property (@(posedge clk) disable iff (rst)
        (!running && !run_start) |=> $stable(stop_pos));

    // R11: start clears the stop position
    a_r11_start_clears: assert property (@(posedge clk) disable iff (rst)
        run_start |=> (running && stop_pos == '0));

    // R11: input assumption, start and stop exclusive
    a_r11_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(run_start && run_stop));
endmodule

bind tsc_packer tsc_packer_chk #(.POS_W(POS_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .run_start (run_start),
    .run_stop  (run_stop),
    .slot_tick (slot_tick),
    .out_valid (out_valid),
    .out_is_ts (out_is_ts),
    .out_addr  (out_addr),
    .stop_pos  (stop_pos),
    .running   (running)
);

// File: tb/tsc_packer_tb_top.sv
module tsc_packer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_start = 1'b0;
    logic        run_stop = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        slot_tick = 1'b0;
    logic [63:0] lanes = '0;
    logic        out_valid;
    logic [15:0] out_word;
    logic        out_is_ts;
    logic [23:0] out_addr;
    logic [23:0] stop_pos;
    logic        running;

    always #4 clk = ~clk;   // 125 MHz

    tsc_packer dut_i (
        .clk(clk), .rst(rst), .run_start(run_start), .run_stop(run_stop),
        .mode(mode), .slot_tick(slot_tick), .lanes(lanes),
        .out_valid(out_valid), .out_word(out_word), .out_is_ts(out_is_ts),
        .out_addr(out_addr), .stop_pos(stop_pos), .running(running)
    );

    typedef struct packed {
        logic [15:0] w;
        logic [23:0] a;
        logic        t;
    } item_t;

    item_t exp_q[$];
    string req_q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    int    words_seen = 0;
    bit    done = 0;

    // reference model state
    logic [15:0] m_ts = '0;
    int          m_idx = 0;
    logic [15:0] m_held = '0;
    bit          m_first = 0;
    bit          m_chg = 0;
    bit          m_run = 0;
    logic [15:0] m_evs [7];
    logic [15:0] m_tscap = '0;
    int          m_pos = 0;
    string       m_req = "R4";

    function automatic logic [15:0] fold_ref(int m, logic [63:0] ln);
        logic [15:0] r = '0;
        int s = (m == 1) ? 2 : (m == 2) ? 4 : 1;
        for (int l = 0; l < 16 / s; l++)
            for (int k = 0; k < s; k++)
                r[l*s+k] = ln[k*16+l];
        return r;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one slot: tick for one cycle then one idle cycle
    task automatic slot(logic [63:0] ln, bit with_stop = 0);
        logic [15:0] ev;
        @(negedge clk);
        lanes = ln;
        slot_tick = 1'b1;
        if (with_stop) run_stop = 1'b1;
        ev = fold_ref(int'(mode), ln);
        if (m_run && !with_stop) begin
            if (m_idx == 0) begin
                m_tscap = m_ts;
                m_chg = 0;
            end
            if (ev != m_held) m_chg = 1;
            m_evs[m_idx] = ev;
            if (m_idx == 6) begin
                if (m_first || m_chg) begin
                    exp_q.push_back('{m_tscap, 24'(m_pos), 1'b1});
                    req_q.push_back("R2");
                    for (int i = 0; i < 7; i++) begin
                        exp_q.push_back('{m_evs[i], 24'(m_pos + 1 + i), 1'b0});
                        req_q.push_back(m_req);
                    end
                    m_pos += 8;
                end
                m_held = ev;
                m_first = 0;
                m_idx = 0;
            end else begin
                m_idx++;
            end
        end
        if (with_stop) m_run = 0;
        m_ts++;
        @(negedge clk);
        slot_tick = 1'b0;
        run_stop = 1'b0;
    endtask

    task automatic do_start();
        @(negedge clk);
        run_start = 1'b1;
        m_run = 1; m_idx = 0; m_held = '0; m_first = 1; m_pos = 0;
        @(negedge clk);
        run_start = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk);
        run_stop = 1'b1;
        m_run = 0; m_idx = 0;
        @(negedge clk);
        run_stop = 1'b0;
    endtask

    task automatic drain();
        repeat (12) @(negedge clk);
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            item_t e;
            string r;
            words_seen++;
            if (exp_q.size() == 0) begin
                check(0, "R7", "unexpected word", int'(out_word), 0);
            end else begin
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(out_word == e.w, r, "word", int'(out_word), int'(e.w));
                check(out_addr == e.a, "R9", "addr", int'(out_addr), int'(e.a));
                check(out_is_ts == e.t, "R3", "ts flag", int'(out_is_ts), int'(e.t));
            end
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [63:0] keep;
        int seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(!out_valid, "R1", "out_valid", int'(out_valid), 0);
        check(stop_pos == 0, "R1", "stop_pos", int'(stop_pos), 0);
        check(!running, "R1", "running", int'(running), 0);

        // R10: ticks before any start emit nothing
        for (int i = 0; i < 9; i++) slot(rnd64());
        drain();
        check(words_seen == 0, "R10", "idle words", words_seen, 0);

        // R2 R3 R4 R9: mode 0 clusters
        do_start();
        check(running, "R11", "running after start", int'(running), 1);
        mode = 2'd0; m_req = "R4";
        for (int i = 0; i < 21; i++) slot(rnd64());
        keep = lanes;
        drain();

        // R7: unchanged input suppresses two clusters
        seen = words_seen;
        for (int i = 0; i < 14; i++) slot(keep);
        drain();
        check(words_seen == seen, "R7", "suppressed words", words_seen - seen, 0);
        check(stop_pos == 24, "R7", "stop_pos after suppression", int'(stop_pos), 24);
        // next changed cluster carries the advanced timestamp
        for (int i = 0; i < 7; i++) slot(i == 3 ? ~keep : keep);
        drain();

        // R5: two sub-samples
        mode = 2'd1; m_req = "R5";
        for (int i = 0; i < 14; i++) slot(rnd64());
        drain();
        // R6: four sub-samples, then reserved code
        mode = 2'd2; m_req = "R6";
        for (int i = 0; i < 14; i++) slot(rnd64());
        mode = 2'd3;
        for (int i = 0; i < 7; i++) slot(rnd64());
        drain();

        // R10: stop with a partial cluster
        mode = 2'd0; m_req = "R4";
        for (int i = 0; i < 3; i++) slot(rnd64());
        do_stop();
        drain();
        check(!running, "R10", "running after stop", int'(running), 0);
        check(stop_pos == 24'(m_pos), "R10", "stop_pos", int'(stop_pos), m_pos);
        seen = words_seen;
        for (int i = 0; i < 10; i++) slot(rnd64());
        drain();
        check(words_seen == seen, "R10", "words while stopped", words_seen - seen, 0);
        check(stop_pos == 24'(m_pos), "R10", "stop_pos held", int'(stop_pos), m_pos);

        // R8 R11: restart, all-zero cluster still emitted at address 0
        do_start();
        check(stop_pos == 0, "R11", "stop_pos after start", int'(stop_pos), 0);
        m_req = "R8";
        seen = words_seen;
        for (int i = 0; i < 7; i++) slot('0);
        drain();
        check(words_seen - seen == 8, "R8", "first cluster words", words_seen - seen, 8);

        // R11: stop on the seventh tick drops the cluster
        m_req = "R4";
        seen = words_seen;
        for (int i = 0; i < 6; i++) slot(rnd64());
        slot(rnd64(), 1'b1);
        drain();
        check(words_seen == seen, "R11", "dropped cluster", words_seen - seen, 0);
        check(stop_pos == 8, "R11", "stop_pos", int'(stop_pos), 8);

        check(exp_q.size() == 0, "R3", "pending items", exp_q.size(), 0);
        done = 1;
        summary();
        $finish;
    end
endmodule